// File: doc/BRIEF.md
# SD Host Data Timeout Timer

This block is the data-path watchdog of an SD/MMC host controller. Software programs a 32-bit timeout period, counted in card clock cycles, and clears a data-timeout flag with a write-one-to-clear status write. Software should program the period before it starts a transfer. The host data path reports two state indications: waiting for read data from the card, and card busy.

A down-counter takes the period as its starting value. It counts down only while one of the two indications is high, and only on cycles where the card clock is enabled. If the count reaches zero while the data path is still in one of those states, the sticky timeout flag is raised.

The counter reloads each time the data path enters either state from any other state, and also on an explicit transfer-start strobe. The current count is visible at a port.

Top module: `dp_data_timeout`

## Requirements
- R1: The period register resets to zero and takes `period_wdata_i` on a cycle with `period_wr_i` high. A new period is used only at the next reload, so a count already running is not affected.
- R2: After reset, `count_o` is 0 and `timeout_o` is 0.
- R3: On the first clock edge at which `dp_wait_rd_i | dp_busy_i` is high after an edge where both were low, `count_o` loads the period and does not decrement on that edge.
- R4: While a state indication stays high and `card_clk_en_i` is high, `count_o` falls by one per clock edge until it reaches 0, and then holds at 0.
- R5: With `card_clk_en_i` low, `count_o` holds its value even while a state indication is high.
- R6: While both state indications are low and no start strobe is given, `count_o` holds and `timeout_o` cannot rise.
- R7: `timeout_o` rises at the same edge at which `count_o` steps from 1 to 0 while a state indication is high.
- R8: A period of zero raises `timeout_o` at the entry edge of R3.
- R9: `timeout_o` stays high until a cycle with `stat_wr_i` high and `stat_tmo_bit_i` = 1 (write-one-to-clear). A status write with the bit at 0 leaves the flag unchanged.
- R10: When a timeout and a clearing write fall in the same cycle, the flag ends up set.
- R11: A cycle with `xfer_start_i` high reloads `count_o` from the period, in any state, and no decrement happens on that edge.
- R12: Moving directly between the read-wait and busy indications, with at least one of them high on every cycle, does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| card_clk_en_i | input | 1 | Card clock enable; the count advances only when high |
| period_wr_i | input | 1 | Write strobe for the period register |
| period_wdata_i | input | CNT_W | Period value in card clock cycles |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_tmo_bit_i | input | 1 | Value written to the timeout status bit (1 clears) |
| xfer_start_i | input | 1 | Transfer start strobe, reloads the counter |
| dp_wait_rd_i | input | 1 | Data path is waiting for read data |
| dp_busy_i | input | 1 | Data path sees the card busy |
| timeout_o | output | 1 | Sticky data-timeout flag |
| count_o | output | CNT_W | Current counter value |

## Verification
A wrong load or enable condition in this block shows at `count_o` on the very next clock edge, so the bench compares the count after every single cycle against a count it computes from the period and the enable pattern. A wrong terminal-count decision shows as `timeout_o` rising one edge early or late, or not at all. The sweep over small periods catches that, with zero and one as the edge cases. A missed entry detection shows as a stale count after a return from an idle stretch.

// File: rtl/dp_tmo_pkg.sv
package dp_tmo_pkg;
  parameter int unsigned CNT_W = 32;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/dp_tmo_period_reg.sv
module dp_tmo_period_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] period_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   period_o <= '0;
    else if (wr_i) period_o <= wdata_i;
  end
endmodule

// File: rtl/dp_tmo_seq.sv
module dp_tmo_seq
  import dp_tmo_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wait_rd_i,
  input  logic    busy_i,
  input  logic    start_i,
  input  logic    clk_en_i,
  output logic    active_o,
  output logic    entry_o,
  output cnt_op_e op_o
);
  logic active_q;

  assign active_o = wait_rd_i | busy_i;
  assign entry_o  = active_o & ~active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_o;
  end

  always_comb begin
    if (entry_o || start_i)       op_o = CNT_LOAD;
    else if (active_o && clk_en_i) op_o = CNT_DEC;
    else                           op_o = CNT_HOLD;
  end
endmodule

// File: rtl/dp_tmo_counter.sv
module dp_tmo_counter
  import dp_tmo_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_op_e      op_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] count_o,
  output logic         hit_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic zero_q;
  assign zero_q = (count_o == '0);

  // a zero period expires on load; otherwise expiry is the step from 1 to 0
  always_comb begin
    unique case (op_i)
      CNT_LOAD: hit_o = (period_i == '0);
      CNT_DEC:  hit_o = (count_o == ONE);
      default:  hit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else begin
      unique case (op_i)
        CNT_LOAD: count_o <= period_i;
        CNT_DEC:  if (!zero_q) count_o <= count_o - ONE;
        default:  count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/dp_tmo_flag.sv
module dp_tmo_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  // set dominates a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (hit_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> flag_o);
endmodule

// File: rtl/dp_data_timeout.sv
module dp_data_timeout
  import dp_tmo_pkg::*;
#(
  parameter int unsigned CNT_W = dp_tmo_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             card_clk_en_i,
  input  logic             period_wr_i,
  input  logic [CNT_W-1:0] period_wdata_i,
  input  logic             stat_wr_i,
  input  logic             stat_tmo_bit_i,
  input  logic             xfer_start_i,
  input  logic             dp_wait_rd_i,
  input  logic             dp_busy_i,
  output logic             timeout_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] period_q;
  logic             active, entry, hit, clr;
  cnt_op_e          op;

  assign clr = stat_wr_i & stat_tmo_bit_i;

  dp_tmo_period_reg #(.W(CNT_W)) u_period (
    .clk_i, .rst_ni, .wr_i(period_wr_i), .wdata_i(period_wdata_i), .period_o(period_q)
  );

  dp_tmo_seq u_seq (
    .clk_i, .rst_ni, .wait_rd_i(dp_wait_rd_i), .busy_i(dp_busy_i),
    .start_i(xfer_start_i), .clk_en_i(card_clk_en_i),
    .active_o(active), .entry_o(entry), .op_o(op)
  );

  dp_tmo_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .op_i(op), .period_i(period_q), .count_o(count_o), .hit_o(hit)
  );

  dp_tmo_flag u_flag (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(clr), .flag_o(timeout_o)
  );

  // R3
  entry_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> count_o == $past(period_q));

  // R4
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !entry && !xfer_start_i && card_clk_en_i && count_o != '0)
      |=> count_o == $past(count_o) - CNT_W'(1));

  // R5
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_clk_en_i && !entry && !xfer_start_i) |=> $stable(count_o));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dp_wait_rd_i && !dp_busy_i && !xfer_start_i)
      |=> ($stable(count_o) && !$rose(timeout_o)));

  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !clr) |=> timeout_o);
endmodule

// File: tb/dp_data_timeout_test.sv
module dp_data_timeout_test;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pwr = 1'b0, swr = 1'b0, sbit = 1'b0, start = 1'b0, wrd = 1'b0, bsy = 1'b0;
  logic [W-1:0] pdata = '0;
  logic         tmo;
  logic [W-1:0] cnt;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dp_data_timeout uut (
    .clk_i(clk), .rst_ni(rst_n), .card_clk_en_i(en), .period_wr_i(pwr),
    .period_wdata_i(pdata), .stat_wr_i(swr), .stat_tmo_bit_i(sbit),
    .xfer_start_i(start), .dp_wait_rd_i(wrd), .dp_busy_i(bsy),
    .timeout_o(tmo), .count_o(cnt)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic set_period(logic [W-1:0] p);
    pwr = 1'b1; pdata = p; tick(); pwr = 1'b0;
  endtask

  task automatic clear_flag();
    swr = 1'b1; sbit = 1'b1; tick(); swr = 1'b0; sbit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] exp_c;
    logic         exp_f;

    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 count", cnt, 0);
    chk("R2 flag", W'(tmo), 0);
    // R1 period resets to zero: entry times out at once
    wrd = 1'b1; en = 1'b1; tick();
    chk("R1 zero period count", cnt, 0);
    chk("R1 zero period flag", W'(tmo), 1);
    wrd = 1'b0; tick(); clear_flag();

    // sweep: period x enable pattern x state
    for (int p = 0; p <= 6; p++) begin
      for (int mode = 0; mode < 2; mode++) begin
        for (int st = 0; st < 2; st++) begin
          en = 1'b1;
          set_period(W'(p));
          clear_flag();
          chk("R9 cleared", W'(tmo), 0);
          if (st == 0) wrd = 1'b1; else bsy = 1'b1;
          tick();
          chk("R3 entry load", cnt, W'(p));
          chk("R8 entry flag", W'(tmo), W'(p == 0));
          exp_c = W'(p); exp_f = (p == 0);
          for (int k = 0; k < 2*p + 3; k++) begin
            en = (mode == 0) ? 1'b1 : (k % 2 == 0);
            tick();
            if (en && exp_c != 0) begin
              exp_c = exp_c - 1;
              if (exp_c == 0) exp_f = 1'b1;
            end
            chk(mode == 0 ? "R4 count" : "R5 count", cnt, exp_c);
            chk("R7 flag", W'(tmo), W'(exp_f));
          end
          wrd = 1'b0; bsy = 1'b0; en = 1'b1;
          tick();
        end
      end
    end

    // R6 idle hold then re-entry
    set_period(10); clear_flag();
    wrd = 1'b1; tick();
    tick(); tick(); tick();
    chk("R4 running", cnt, 7);
    wrd = 1'b0;
    for (int k = 0; k < 4; k++) tick();
    chk("R6 idle hold", cnt, 7);
    chk("R6 no timeout", W'(tmo), 0);
    wrd = 1'b1; tick();
    chk("R3 re-entry reload", cnt, 10);
    // R12 direct switch wait -> busy
    tick();
    chk("R4 step", cnt, 9);
    wrd = 1'b0; bsy = 1'b1; tick();
    chk("R12 no reload", cnt, 8);
    // R1 new period does not touch running count
    pwr = 1'b1; pdata = 3; tick(); pwr = 1'b0;
    chk("R1 running unaffected", cnt, 7);
    bsy = 1'b0; tick();
    start = 1'b1; tick(); start = 1'b0;
    chk("R11 start while idle", cnt, 3);
    tick();
    chk("R6 hold after start", cnt, 3);
    bsy = 1'b1; tick(); tick();
    chk("R4 busy step", cnt, 2);
    start = 1'b1; tick(); start = 1'b0;
    chk("R11 start while active", cnt, 3);
    bsy = 1'b0; tick();

    // R10 set beats simultaneous clear
    set_period(1); clear_flag();
    wrd = 1'b1; tick();
    chk("R3 load one", cnt, 1);
    chk("R7 not yet", W'(tmo), 0);
    swr = 1'b1; sbit = 1'b1; tick(); swr = 1'b0; sbit = 1'b0;
    chk("R10 set wins", W'(tmo), 1);
    chk("R4 at zero", cnt, 0);
    tick();
    chk("R4 holds zero", cnt, 0);
    // R9 write of zero keeps flag
    swr = 1'b1; sbit = 1'b0; tick(); swr = 1'b0;
    chk("R9 write zero", W'(tmo), 1);
    wrd = 1'b0; tick(); tick();
    chk("R9 sticky idle", W'(tmo), 1);
    clear_flag();
    chk("R9 w1c", W'(tmo), 0);

    summary();
    $finish;
  end
endmodule